// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the software-facing register port of an eight-line interrupt controller. A processor reaches it through a synchronous byte bus with a one-bit address. Writes at address 0 are decoded three ways: a start-of-initialization word, a mode command, or an end-of-interrupt and rotation command. Writes at address 1 either load the interrupt mask or supply the next word of the initialization sequence, depending on where that sequence stands. Reads return the request vector, the in-service vector or the mask. When poll is armed, a read instead returns the current winner and acknowledges it.

The port holds the controller's mode flags, vector base, mask, priority rotation offset and in-service vector. The request capture logic and the priority resolver sit outside. The resolver presents its current winner on `win_valid_i`/`win_line_i`. The processor's acknowledge cycle arrives as `inta_i`. The port reports each accepted acknowledge and each in-service clear to its neighbours as single-cycle strobes. An initialization start is reported with `init_o`, so that the capture logic can forget past edges.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset the mask, in-service vector, rotation offset, vector base, every mode flag, every strobe and `rdata` are all zero.
- R2: A write at address 0 with bit 4 set starts initialization. It clears mask, in-service vector, offset, rotate-on-auto-EOI, special mask, read select, poll, special-nested and auto-EOI. It latches fourth-word-needed from bit 0, single mode from bit 1 and level-trigger from bit 3, and pulses `init_o`.
- R3: After an initialization start, the next address-1 write sets `base_o` to the data AND 0xF8. The next one is a cascade word, which is skipped in single mode. A fourth word follows only when it was flagged. Every later address-1 write loads the mask.
- R4: The fourth initialization word sets special-nested from bit 4 and auto-EOI from bit 1.
- R5: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. When bit 1 is set, bit 0 becomes the read select (1 = in-service, 0 = request). When bit 6 is set, bit 5 becomes special mask. A cleared enable bit leaves its flag unchanged.
- R6: Other address-0 writes carry a command in bits 7:5. Commands 0 and 4 set rotate-on-auto-EOI to bit 7.
- R7: Commands 1 and 5 clear the highest-priority in-service bit. That bit is the first set bit found scanning upward from the offset, modulo 8. The clear pulses `eoi_o` with that line, and command 5 also sets the offset to line+1 mod 8. With no bit in service, nothing changes and `eoi_o` stays low.
- R8: Command 3 clears the in-service bit named in bits 2:0 and pulses `eoi_o`. Command 6 sets the offset to (bits 2:0)+1 mod 8. Command 7 does both. Command 2 changes nothing.
- R9: A read while poll is armed returns 0x80 OR the winner's line if `win_valid_i` is set, and acknowledges it as in R11. With no winner it returns 0. Either way poll is disarmed.
- R10: A read without poll returns, at address 0, the in-service vector (read select 1) or `req_i` (read select 0), and at address 1 the mask.
- R11: An acknowledge (`inta_i` or a poll read, with `win_valid_i`) pulses `ack_o` with the line. Without auto-EOI it sets that in-service bit. With auto-EOI it sets no bit, and if rotate-on-auto-EOI is on it sets the offset to line+1 mod 8.
- R12: Every register effect, strobe and read value appears at the outputs right after the clock edge that samples the access, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| req_i | input | 8 | Request vector from capture logic |
| win_valid_i | input | 1 | Resolver has a winner |
| win_line_i | input | 3 | Winning line |
| inta_i | input | 1 | Processor acknowledge cycle |
| init_o | output | 1 | Initialization start pulse |
| need4_o | output | 1 | Fourth word flagged |
| single_o | output | 1 | Single (non-cascaded) mode |
| ltim_o | output | 1 | Level-triggered inputs |
| sfnm_o | output | 1 | Special fully nested mode |
| aeoi_o | output | 1 | Auto end-of-interrupt |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| spec_mask_o | output | 1 | Special mask mode |
| base_o | output | 8 | Vector base, low three bits zero |
| mask_o | output | 8 | Interrupt mask |
| offset_o | output | 3 | Priority rotation offset (lowest-priority line + 1) |
| isr_o | output | 8 | In-service vector |
| ack_o | output | 1 | Acknowledge accepted pulse |
| ack_line_o | output | 3 | Line of last acknowledge |
| eoi_o | output | 1 | In-service clear pulse |
| eoi_line_o | output | 3 | Line of last clear |

## Verification
Every result is due exactly one edge after its access: state, strobes and read data are all registered at the edge that samples `wr_en`, `rd_en` or `inta_i`. The bench drives each access at a falling edge, lets one rising edge pass and samples at the next falling edge. The strobes are checked there, because they are gone after the following edge. One check samples the mask both before and after the edge of its write, to pin the one-cycle latency.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN    = 2'd0,
    SEQ_BASE   = 2'd1,
    SEQ_CASC   = 2'd2,
    SEQ_FOURTH = 2'd3
  } seq_t;

  // address-0 decode bits
  localparam int unsigned B_INIT   = 4;
  localparam int unsigned B_MODE   = 3;
  // initialization start bits
  localparam int unsigned B_NEED4  = 0;
  localparam int unsigned B_SINGLE = 1;
  localparam int unsigned B_LTIM   = 3;
  // fourth word bits
  localparam int unsigned B_SFNM   = 4;
  localparam int unsigned B_AEOI   = 1;
  // mode command bits
  localparam int unsigned B_POLL   = 2;
  localparam int unsigned B_RSEL_EN = 1;
  localparam int unsigned B_RSEL   = 0;
  localparam int unsigned B_SMM_EN = 6;
  localparam int unsigned B_SMM    = 5;

  // command codes in bits 7:5
  localparam logic [2:0] OP_ROT_OFF  = 3'd0;
  localparam logic [2:0] OP_EOI      = 3'd1;
  localparam logic [2:0] OP_NOP      = 3'd2;
  localparam logic [2:0] OP_SPEC_EOI = 3'd3;
  localparam logic [2:0] OP_ROT_ON   = 3'd4;
  localparam logic [2:0] OP_EOI_ROT  = 3'd5;
  localparam logic [2:0] OP_SET_PRI  = 3'd6;
  localparam logic [2:0] OP_SPEC_ROT = 3'd7;

endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic [DW-1:0] vec_i,
  input  logic [LW-1:0] off_i,
  output logic          found_o,
  output logic [LW-1:0] line_o
);
  // first set bit scanning upward from off_i, wrapping
  always_comb begin
    found_o = 1'b0;
    line_o  = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      logic [LW-1:0] idx;
      idx = off_i + LW'(i);
      if (vec_i[idx]) begin
        found_o = 1'b1;
        line_o  = idx;
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          wr1_i,
  input  logic [DW-1:0] wdata_i,
  output logic          mask_we_o,
  output logic          need4_o,
  output logic          single_o,
  output logic          ltim_o,
  output logic          sfnm_o,
  output logic          aeoi_o,
  output logic [DW-1:0] base_o
);
  localparam logic [DW-1:0] BASE_KEEP = {{(DW-LW){1'b1}}, {LW{1'b0}}};

  seq_t seq_q, seq_n;
  logic need4_q, need4_n, single_q, single_n, ltim_q, ltim_n;
  logic sfnm_q, sfnm_n, aeoi_q, aeoi_n;
  logic [DW-1:0] base_q, base_n;
  logic unused_bits;

  assign unused_bits = ^wdata_i;
  assign mask_we_o = wr1_i && !start_i && (seq_q == SEQ_RUN);

  always_comb begin
    seq_n    = seq_q;
    need4_n  = need4_q;
    single_n = single_q;
    ltim_n   = ltim_q;
    sfnm_n   = sfnm_q;
    aeoi_n   = aeoi_q;
    base_n   = base_q;
    if (start_i) begin
      seq_n    = SEQ_BASE;
      need4_n  = wdata_i[B_NEED4];
      single_n = wdata_i[B_SINGLE];
      ltim_n   = wdata_i[B_LTIM];
      sfnm_n   = 1'b0;
      aeoi_n   = 1'b0;
      base_n   = '0;
    end else if (wr1_i) begin
      case (seq_q)
        SEQ_BASE: begin
          base_n = wdata_i & BASE_KEEP;
          if (single_q) seq_n = need4_q ? SEQ_FOURTH : SEQ_RUN;
          else          seq_n = SEQ_CASC;
        end
        SEQ_CASC:   seq_n = need4_q ? SEQ_FOURTH : SEQ_RUN;
        SEQ_FOURTH: begin
          sfnm_n = wdata_i[B_SFNM];
          aeoi_n = wdata_i[B_AEOI];
          seq_n  = SEQ_RUN;
        end
        default: seq_n = SEQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q    <= SEQ_RUN;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
      ltim_q   <= 1'b0;
      sfnm_q   <= 1'b0;
      aeoi_q   <= 1'b0;
      base_q   <= '0;
    end else begin
      seq_q    <= seq_n;
      need4_q  <= need4_n;
      single_q <= single_n;
      ltim_q   <= ltim_n;
      sfnm_q   <= sfnm_n;
      aeoi_q   <= aeoi_n;
      base_q   <= base_n;
    end
  end

  assign need4_o  = need4_q;
  assign single_o = single_q;
  assign ltim_o   = ltim_q;
  assign sfnm_o   = sfnm_q;
  assign aeoi_o   = aeoi_q;
  assign base_o   = base_q;
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] req_i,
  input  logic          win_valid_i,
  input  logic [LW-1:0] win_line_i,
  input  logic          inta_i,
  output logic          init_o,
  output logic          need4_o,
  output logic          single_o,
  output logic          ltim_o,
  output logic          sfnm_o,
  output logic          aeoi_o,
  output logic          rot_aeoi_o,
  output logic          spec_mask_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] mask_o,
  output logic [LW-1:0] offset_o,
  output logic [DW-1:0] isr_o,
  output logic          ack_o,
  output logic [LW-1:0] ack_line_o,
  output logic          eoi_o,
  output logic [LW-1:0] eoi_line_o
);
  localparam logic [LW-1:0] ONE = {{(LW-1){1'b0}}, 1'b1};

  logic wr0, wr1, is_init, is_mode, is_cmd, mask_we, accept;
  logic [2:0]    op;
  logic [LW-1:0] op_line;
  logic          pick_found;
  logic [LW-1:0] pick_line;

  logic [DW-1:0] mask_q, mask_n, isr_q, isr_n, rdata_q, rdata_n, set_v, clr_v;
  logic [LW-1:0] off_q, off_n, ackl_q, ackl_n, eoil_q, eoil_n;
  logic poll_q, poll_n, rsel_q, rsel_n, smm_q, smm_n, rot_q, rot_n;
  logic init_q, init_n, ack_q, ack_n, eoi_q, eoi_n;

  assign wr0     = wr_en && !addr;
  assign wr1     = wr_en && addr;
  assign is_init = wr0 && wdata[B_INIT];
  assign is_mode = wr0 && !wdata[B_INIT] && wdata[B_MODE];
  assign is_cmd  = wr0 && !wdata[B_INIT] && !wdata[B_MODE];
  assign op      = wdata[7:5];
  assign op_line = wdata[LW-1:0];
  assign accept  = win_valid_i && (inta_i || (rd_en && poll_q));

  pic_init_seq #(.DW(DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (is_init),
    .wr1_i    (wr1),
    .wdata_i  (wdata),
    .mask_we_o(mask_we),
    .need4_o  (need4_o),
    .single_o (single_o),
    .ltim_o   (ltim_o),
    .sfnm_o   (sfnm_o),
    .aeoi_o   (aeoi_o),
    .base_o   (base_o)
  );

  pic_prio_pick #(.DW(DW)) u_pick (
    .vec_i  (isr_q),
    .off_i  (off_q),
    .found_o(pick_found),
    .line_o (pick_line)
  );

  always_comb begin
    mask_n  = mask_q;
    off_n   = off_q;
    poll_n  = poll_q;
    rsel_n  = rsel_q;
    smm_n   = smm_q;
    rot_n   = rot_q;
    ackl_n  = ackl_q;
    eoil_n  = eoil_q;
    rdata_n = rdata_q;
    ack_n   = 1'b0;
    eoi_n   = 1'b0;
    init_n  = 1'b0;
    set_v   = '0;
    clr_v   = '0;

    if (accept) begin
      ack_n  = 1'b1;
      ackl_n = win_line_i;
      if (!aeoi_o)    set_v[win_line_i] = 1'b1;
      else if (rot_q) off_n = win_line_i + ONE;
    end

    if (rd_en) begin
      if (poll_q) begin
        rdata_n = win_valid_i ? {1'b1, {(DW-1-LW){1'b0}}, win_line_i} : '0;
        poll_n  = 1'b0;
      end else if (addr) begin
        rdata_n = mask_q;
      end else begin
        rdata_n = rsel_q ? isr_q : req_i;
      end
    end

    if (mask_we) mask_n = wdata;

    if (is_mode) begin
      if (wdata[B_POLL])    poll_n = 1'b1;
      if (wdata[B_RSEL_EN]) rsel_n = wdata[B_RSEL];
      if (wdata[B_SMM_EN])  smm_n  = wdata[B_SMM];
    end

    if (is_cmd) begin
      case (op)
        OP_ROT_OFF, OP_ROT_ON: rot_n = wdata[7];
        OP_EOI, OP_EOI_ROT: begin
          if (pick_found) begin
            clr_v[pick_line] = 1'b1;
            eoi_n  = 1'b1;
            eoil_n = pick_line;
            if (op == OP_EOI_ROT) off_n = pick_line + ONE;
          end
        end
        OP_SPEC_EOI: begin
          clr_v[op_line] = 1'b1;
          eoi_n  = 1'b1;
          eoil_n = op_line;
        end
        OP_SET_PRI: off_n = op_line + ONE;
        OP_SPEC_ROT: begin
          clr_v[op_line] = 1'b1;
          eoi_n  = 1'b1;
          eoil_n = op_line;
          off_n  = op_line + ONE;
        end
        default: ;
      endcase
    end

    isr_n = (isr_q & ~clr_v) | set_v;

    if (is_init) begin
      init_n = 1'b1;
      isr_n  = '0;
      mask_n = '0;
      off_n  = '0;
      poll_n = 1'b0;
      rsel_n = 1'b0;
      smm_n  = 1'b0;
      rot_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      isr_q   <= '0;
      off_q   <= '0;
      poll_q  <= 1'b0;
      rsel_q  <= 1'b0;
      smm_q   <= 1'b0;
      rot_q   <= 1'b0;
      ackl_q  <= '0;
      eoil_q  <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
      eoi_q   <= 1'b0;
      init_q  <= 1'b0;
    end else begin
      mask_q  <= mask_n;
      isr_q   <= isr_n;
      off_q   <= off_n;
      poll_q  <= poll_n;
      rsel_q  <= rsel_n;
      smm_q   <= smm_n;
      rot_q   <= rot_n;
      ackl_q  <= ackl_n;
      eoil_q  <= eoil_n;
      rdata_q <= rdata_n;
      ack_q   <= ack_n;
      eoi_q   <= eoi_n;
      init_q  <= init_n;
    end
  end

  assign rdata       = rdata_q;
  assign init_o      = init_q;
  assign rot_aeoi_o  = rot_q;
  assign spec_mask_o = smm_q;
  assign mask_o      = mask_q;
  assign offset_o    = off_q;
  assign isr_o       = isr_q;
  assign ack_o       = ack_q;
  assign ack_line_o  = ackl_q;
  assign eoi_o       = eoi_q;
  assign eoi_line_o  = eoil_q;
endmodule

// File: rtl/pic_cmd_port_chk.sv
module pic_cmd_port_chk #(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          wr_en,
  input logic          poll_q,
  input logic          init_o,
  input logic          aeoi_o,
  input logic [DW-1:0] mask_o,
  input logic [DW-1:0] isr_o,
  input logic [LW-1:0] offset_o,
  input logic          ack_o,
  input logic [LW-1:0] ack_line_o,
  input logic          eoi_o,
  input logic [LW-1:0] eoi_line_o
);
  // R2: an initialization start leaves mask, in-service and offset cleared
  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |-> (mask_o == '0 && isr_o == '0 && offset_o == '0));

  // R9: a read while polling disarms poll
  a_r9_poll_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_q && !wr_en) |=> !poll_q);

  // R7 / R8: a reported clear leaves its line out of service
  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_o && !(ack_o && ack_line_o == eoi_line_o)) |-> !isr_o[eoi_line_o]);

  // R11: an acknowledge without auto-EOI puts the line in service
  a_r11_ack_records: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !$past(aeoi_o) && !init_o && !(eoi_o && eoi_line_o == ack_line_o))
      |-> isr_o[ack_line_o]);
endmodule

bind pic_cmd_port pic_cmd_port_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .poll_q    (poll_q),
  .init_o    (init_o),
  .aeoi_o    (aeoi_o),
  .mask_o    (mask_o),
  .isr_o     (isr_o),
  .offset_o  (offset_o),
  .ack_o     (ack_o),
  .ack_line_o(ack_line_o),
  .eoi_o     (eoi_o),
  .eoi_line_o(eoi_line_o)
);

// File: tb/pic_cmd_port_bench.sv
module pic_cmd_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, win_valid = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, req = '0;
  logic [2:0] win_line = '0;
  logic [7:0] rdata, base_o, mask_o, isr_o;
  logic [2:0] offset_o, ack_line_o, eoi_line_o;
  logic init_o, need4_o, single_o, ltim_o, sfnm_o, aeoi_o, rot_aeoi_o, spec_mask_o, ack_o, eoi_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] isr_m;

  always #2 clk = ~clk;

  pic_cmd_port u_pic_cmd_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_i(req), .win_valid_i(win_valid),
    .win_line_i(win_line), .inta_i(inta), .init_o(init_o), .need4_o(need4_o),
    .single_o(single_o), .ltim_o(ltim_o), .sfnm_o(sfnm_o), .aeoi_o(aeoi_o),
    .rot_aeoi_o(rot_aeoi_o), .spec_mask_o(spec_mask_o), .base_o(base_o),
    .mask_o(mask_o), .offset_o(offset_o), .isr_o(isr_o), .ack_o(ack_o),
    .ack_line_o(ack_line_o), .eoi_o(eoi_o), .eoi_line_o(eoi_line_o)
  );

  task automatic chk(input string req_tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ack_line(input int l);
    @(negedge clk);
    win_valid = 1'b1; win_line = 3'(l); inta = 1'b1;
    @(negedge clk);
    inta = 1'b0; win_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", int'(mask_o), 0);
    chk("R1 isr", int'(isr_o), 0);
    chk("R1 offset", int'(offset_o), 0);
    chk("R1 base", int'(base_o), 0);
    chk("R1 flags", int'({need4_o, single_o, ltim_o, sfnm_o, aeoi_o, rot_aeoi_o, spec_mask_o, init_o, ack_o, eoi_o}), 0);
    chk("R1 rdata", int'(rdata), 0);

    // R2 R3 R4 sweep over every initialization flag combination
    for (int c = 0; c < 8; c++) begin
      logic [7:0] bv, mv;
      bv = 8'(8'h3F + c * 8);
      mv = 8'hA5 ^ 8'(c);
      wr(1'b0, 8'h10 | 8'(c[0]) | (8'(c[1]) << 1) | (8'(c[2]) << 3));
      chk("R2 init pulse", int'(init_o), 1);
      chk("R2 mask cleared", int'(mask_o), 0);
      chk("R2 latched flags", int'({need4_o, single_o, ltim_o}), int'({c[0], c[1], c[2]}));
      chk("R2 nested/aeoi cleared", int'({sfnm_o, aeoi_o}), 0);
      wr(1'b1, bv);
      chk("R3 base", int'(base_o), int'(bv & 8'hF8));
      if (!c[1]) begin
        wr(1'b1, 8'h04);
        chk("R3 cascade word not mask", int'(mask_o), 0);
        chk("R3 cascade word keeps base", int'(base_o), int'(bv & 8'hF8));
      end
      if (c[0]) begin
        wr(1'b1, {3'b0, c[2], 2'b0, c[1], 1'b0});
        chk("R4 fourth word", int'({sfnm_o, aeoi_o}), int'({c[2], c[1]}));
        chk("R3 fourth word not mask", int'(mask_o), 0);
      end
      wr(1'b1, mv);
      chk("R3 mask after sequence", int'(mask_o), int'(mv));
      rd(1'b1);
      chk("R10 read mask", int'(rdata), int'(mv));
    end

    // cascaded, fourth word, no auto-EOI
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h00);
    chk("R4 aeoi off", int'(aeoi_o), 0);

    // R12 latency of a mask write
    @(negedge clk);
    wr_en = 1'b1; addr = 1'b1; wdata = 8'h81;
    #1 chk("R12 not before edge", int'(mask_o), 0);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R12 after edge", int'(mask_o), 8'h81);

    // R5 R10 mode command and read select
    req = 8'h3C;
    wr(1'b0, 8'h0A);
    rd(1'b0);
    chk("R10 read request", int'(rdata), 8'h3C);
    ack_line(3);
    chk("R11 ack pulse", int'({ack_o, ack_line_o}), int'({1'b1, 3'd3}));
    wr(1'b0, 8'h0B);
    rd(1'b0);
    chk("R10 read in-service", int'(rdata), 8'h08);
    wr(1'b0, 8'h09);
    rd(1'b0);
    chk("R5 select kept without enable", int'(rdata), 8'h08);
    wr(1'b0, 8'h68);
    chk("R5 special mask on", int'(spec_mask_o), 1);
    wr(1'b0, 8'h28);
    chk("R5 special mask kept", int'(spec_mask_o), 1);
    wr(1'b0, 8'h48);
    chk("R5 special mask off", int'(spec_mask_o), 0);

    // R9 poll
    wr(1'b0, 8'h0C);
    win_valid = 1'b1; win_line = 3'd6;
    rd(1'b0);
    win_valid = 1'b0;
    chk("R9 poll value", int'(rdata), 8'h86);
    chk("R9 poll ack", int'({ack_o, ack_line_o}), int'({1'b1, 3'd6}));
    chk("R11 poll sets in-service", int'(isr_o), 8'h48);
    rd(1'b1);
    chk("R9 poll disarmed", int'(rdata), 8'h81);
    wr(1'b0, 8'h0C);
    rd(1'b1);
    chk("R9 empty poll", int'(rdata), 0);
    chk("R9 empty poll no ack", int'(ack_o), 0);
    rd(1'b1);
    chk("R9 disarmed after empty", int'(rdata), 8'h81);
    wr(1'b0, 8'h63); wr(1'b0, 8'h66); wr(1'b1, 8'h00);
    chk("R8 specific clears", int'(isr_o), 0);
    wr(1'b0, 8'h20);
    chk("R7 empty no strobe", int'({eoi_o, isr_o}), 0);

    // R7 R8 R11 rotation sweep
    for (int off = 0; off < 8; off++) begin
      logic [7:0] p;
      logic found, rot;
      int pk;
      p = 8'((off * 73 + 29) & 255);
      rot = off[0];
      wr(1'b0, 8'hC0 | 8'((off + 7) % 8));
      chk("R8 set priority", int'(offset_o), off);
      for (int l = 0; l < 8; l++) if (p[l]) ack_line(l);
      chk("R11 pattern in service", int'(isr_o), int'(p));
      found = 1'b0; pk = 0;
      for (int i = 0; i < 8; i++)
        if (!found && p[(off + i) % 8]) begin found = 1'b1; pk = (off + i) % 8; end
      wr(1'b0, rot ? 8'hA0 : 8'h20);
      isr_m = p & ~(8'(1) << pk);
      chk("R7 highest cleared", int'(isr_o), int'(isr_m));
      chk("R7 strobe", int'({eoi_o, eoi_line_o}), int'({1'b1, 3'(pk)}));
      chk("R7 offset", int'(offset_o), rot ? (pk + 1) % 8 : off);
      for (int l = 0; l < 8; l++)
        if (isr_m[l]) begin
          wr(1'b0, 8'h60 | 8'(l));
          chk("R8 specific strobe", int'({eoi_o, eoi_line_o}), int'({1'b1, 3'(l)}));
        end
      chk("R8 all cleared", int'(isr_o), 0);
    end

    // R8 command 7 and command 2
    ack_line(4);
    wr(1'b0, 8'hE4);
    chk("R8 clear and rotate", int'({isr_o, offset_o}), int'({8'h00, 3'd5}));
    ack_line(1);
    wr(1'b0, 8'h40);
    chk("R8 no-op", int'({isr_o, offset_o, eoi_o}), int'({8'h02, 3'd5, 1'b0}));
    wr(1'b0, 8'h61);

    // R6 R11 auto-EOI in single mode
    wr(1'b0, 8'h13); wr(1'b1, 8'h08); wr(1'b1, 8'h02);
    chk("R4 aeoi set", int'({aeoi_o, single_o}), 3);
    wr(1'b0, 8'h80);
    chk("R6 rotate on", int'(rot_aeoi_o), 1);
    ack_line(5);
    chk("R11 aeoi rotate", int'({isr_o, offset_o, ack_o}), int'({8'h00, 3'd6, 1'b1}));
    wr(1'b0, 8'h00);
    chk("R6 rotate off", int'(rot_aeoi_o), 0);
    ack_line(2);
    chk("R11 aeoi no rotate", int'({isr_o, offset_o}), int'({8'h00, 3'd6}));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule